// File: doc/BRIEF.md
# E1 Overhead Bit Extractor

This block sits behind an E1 frame aligner and pulls the timeslot-0 and timeslot-16 overhead bits out of the received 2.048 Mb/s stream. It publishes each one as a register that a host can read. Once per received frame, the aligner pulses `frm_stb` and supplies the following:
- the timeslot-0 octet;
- the frame's position (0 to 7) within the CRC sub-multiframe;
- an out-of-frame flag;
- the timeslot-16 octet, with a flag marking frame 0 of the signalling multiframe.

Octet bits are numbered so that the first transmitted bit is bit 7. Frames with an even index carry the alignment word, and frames with an odd index are the non-alignment (NFAS) frames. In an NFAS frame, the octet holds Si at bit 7, A at bit 5, and Sa4..Sa8 at bits 4..0. In the signalling multiframe's frame 0, the timeslot-16 octet holds X at bits 3, 1 and 0, and Y at bit 2.

Each field has its own update rule:
- Si and the Sa group freeze while the aligner reports out-of-frame.
- A follows every NFAS frame.
- X and Y are staged and published one frame later.

A 4-bit national codeword is built from one selected Sa position across the four NFAS frames of a sub-multiframe. It is debounced over two sub-multiframes. A link-identification flag watches the recent Sa7 bits for a majority of zeros.

Top module: `ovx_extract`

## Requirements
- R1: The codeword select value v (0..4) picks Sa(4+v), which is timeslot-0 bit 4-v. Codeword bit 3 comes from frame 1, bit 2 from frame 3, bit 1 from frame 5 and bit 0 from frame 7. The four bits must come from consecutive strobes on frames 1, 3, 5 and 7.
- R2: `nat_cw` changes only one clock after a frame-7 strobe that completes a codeword. It takes the new codeword only if that codeword equals the previous completed codeword, with no restart between the two. The first codeword after reset or after a restart never updates it.
- R3: `si_bits[1]` takes bit 7 of each in-frame even frame, and `si_bits[0]` takes bit 7 of each in-frame odd frame. Both hold while `oof` is 1.
- R4: `sa_bits` takes bits 4..0 of each in-frame odd frame and holds while `oof` is 1.
- R5: `a_bit` takes bit 5 of every odd frame, whether or not `oof` is asserted.
- R6: On a strobe with `smf_start`=1, timeslot-16 bits 3, 1 and 0 (X) and bit 2 (Y) are staged. They appear on `x_bits` {b3,b1,b0} and `y_bit` one clock after the next strobe.
- R7: `link_id` is 1 when at least 2 of the last 3 Sa7 bits (bit 1 of in-frame odd frames) are 0. Before three bits have arrived, the missing ones count as 1.
- R8: While reset is held, every output is 0 and the codeword and Sa7 histories are cleared.
- R9: A change of `cw_sel` discards the partial codeword and the debounce history.
- R10: A strobe with `oof`=1, or any strobe while `cw_sel` is 5..7, discards the partial codeword but keeps the debounce history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_stb | input | 1 | One-cycle pulse per received frame |
| frm_idx | input | 3 | Frame position in the CRC sub-multiframe |
| oof | input | 1 | Aligner reports out of frame |
| ts0_byte | input | 8 | Timeslot-0 octet, bit 7 first on line |
| smf_start | input | 1 | This frame is signalling-multiframe frame 0 |
| ts16_byte | input | 8 | Timeslot-16 octet |
| cw_sel | input | 3 | National codeword position select |
| si_bits | output | 2 | International bits {even frame, odd frame} |
| sa_bits | output | 5 | Sa4..Sa8 |
| a_bit | output | 1 | Remote alarm bit |
| x_bits | output | 3 | Extra bits from timeslot 16 |
| y_bit | output | 1 | Remote signalling-multiframe alarm bit |
| nat_cw | output | 4 | Debounced national codeword |
| link_id | output | 1 | Sa7 zero-majority indication |

## Verification
The bench builds the block with its default parameters: a 3-bit select, 8 frames per sub-multiframe, and a 3-bit Sa7 window with a threshold of 2. These defaults bring every select value within reach, including the three suspending ones. They also cover full debounce sequences across repeated and changing codewords, and link detection switching both on and off. Out-of-frame bursts that land partway through a sub-multiframe are covered as well.

// File: rtl/ovx_pkg.sv
package ovx_pkg;
  // timeslot-0 bit positions (bit 7 is first on line)
  localparam int SI_POS  = 7;
  localparam int A_POS   = 5;
  localparam int SA_MSB  = 4;
  localparam int SA7_POS = 1;
  // timeslot-16 positions in signalling multiframe frame 0
  localparam int X0_POS  = 3;
  localparam int Y_POS   = 2;
  localparam int X1_POS  = 1;
  localparam int X2_POS  = 0;
  localparam int CW_W    = 4;

  function automatic int zeros_in(input logic [7:0] v, input int n);
    int c;
    c = 0;
    for (int i = 0; i < n; i++) if (!v[i]) c++;
    return c;
  endfunction
endpackage

// File: rtl/ovx_cw_debounce.sv
module ovx_cw_debounce import ovx_pkg::*; #(
  parameter int SEL_W = 3,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic [IDX_W-1:0] idx,
  input  logic             oof,
  input  logic [SEL_W-1:0] sel,
  input  logic [4:0]       sa_in,
  output logic [CW_W-1:0]  cw
);
  localparam int POS_W = IDX_W - 1;

  logic [SEL_W-1:0] sel_q;
  logic [CW_W-1:0]  part, hist;
  logic [POS_W:0]   cnt;
  logic             hist_ok;
  logic             restart, sel_ok, bit_in;
  logic [POS_W-1:0] pos;
  logic [CW_W-1:0]  word;

  assign restart = (sel != sel_q);
  assign sel_ok  = (sel <= SEL_W'(4));
  assign pos     = idx[IDX_W-1:1];
  assign bit_in  = sa_in[3'(4 - int'(sel_ok ? sel : '0))];
  assign word    = {part[CW_W-1:1], bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      part    <= '0;
      hist    <= '0;
      cnt     <= '0;
      hist_ok <= 1'b0;
      cw      <= '0;
    end else begin
      sel_q <= sel;
      if (restart) begin
        cnt     <= '0;
        hist_ok <= 1'b0;
      end else if (stb) begin
        if (oof || !sel_ok) begin
          cnt <= '0;
        end else if (idx[0]) begin
          if (pos == '0) begin
            part[CW_W-1] <= bit_in;
            cnt          <= 1;
          end else if ({1'b0, pos} == cnt) begin
            part[CW_W-1-int'(pos)] <= bit_in;
            if (int'(pos) == CW_W-1) begin
              cnt     <= '0;
              hist    <= word;
              hist_ok <= 1'b1;
              if (hist_ok && hist == word) cw <= word;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else begin
            cnt <= '0;
          end
        end
      end
    end
  end

  assert_cw_on_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(cw)) |-> $past(stb && idx[0] && !oof));
  assert_cw_restart_R9: assert property (@(posedge clk) disable iff (rst)
    $past(restart) |-> $stable(cw));
  assert_cw_reset_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cw == '0 && !hist_ok));
endmodule

// File: rtl/ovx_link_detect.sv
module ovx_link_detect import ovx_pkg::*; #(
  parameter int WIN   = 3,
  parameter int MIN_Z = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic shift,
  input  logic bit_in,
  output logic link
);
  logic [WIN-1:0] win_q;
  logic [WIN-1:0] win_n;
  logic [7:0]     win_ext;

  generate
    if (WIN > 1) begin : g_multi
      assign win_n = {win_q[WIN-2:0], bit_in};
    end else begin : g_single
      assign win_n = bit_in;
    end
  endgenerate
  assign win_ext = {{(8-WIN){1'b1}}, win_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '1;
      link  <= 1'b0;
    end else if (shift) begin
      win_q <= win_n;
      link  <= (zeros_in(win_ext, WIN) >= MIN_Z);
    end
  end

  assert_link_on_shift_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(link)) |-> $past(shift));
endmodule

// File: rtl/ovx_extract.sv
module ovx_extract import ovx_pkg::*; #(
  parameter int SEL_W     = 3,
  parameter int IDX_W     = 3,
  parameter int LINK_WIN  = 3,
  parameter int LINK_MINZ = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_stb,
  input  logic [IDX_W-1:0] frm_idx,
  input  logic             oof,
  input  logic [7:0]       ts0_byte,
  input  logic             smf_start,
  input  logic [7:0]       ts16_byte,
  input  logic [SEL_W-1:0] cw_sel,
  output logic [1:0]       si_bits,
  output logic [4:0]       sa_bits,
  output logic             a_bit,
  output logic [2:0]       x_bits,
  output logic             y_bit,
  output logic [CW_W-1:0]  nat_cw,
  output logic             link_id
);
  logic       nfas;
  logic       xy_pend;
  logic [2:0] x_stage;
  logic       y_stage;

  assign nfas = frm_idx[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      si_bits <= '0;
      sa_bits <= '0;
      a_bit   <= 1'b0;
      x_bits  <= '0;
      y_bit   <= 1'b0;
      xy_pend <= 1'b0;
      x_stage <= '0;
      y_stage <= 1'b0;
    end else if (frm_stb) begin
      if (!oof) begin
        if (nfas) begin
          si_bits[0] <= ts0_byte[SI_POS];
          sa_bits    <= ts0_byte[SA_MSB:0];
        end else begin
          si_bits[1] <= ts0_byte[SI_POS];
        end
      end
      if (nfas) a_bit <= ts0_byte[A_POS];
      if (xy_pend) begin
        x_bits <= x_stage;
        y_bit  <= y_stage;
      end
      xy_pend <= smf_start;
      if (smf_start) begin
        x_stage <= {ts16_byte[X0_POS], ts16_byte[X1_POS], ts16_byte[X2_POS]};
        y_stage <= ts16_byte[Y_POS];
      end
    end
  end

  ovx_cw_debounce #(.SEL_W(SEL_W), .IDX_W(IDX_W)) u_cw (
    .clk(clk), .rst(rst), .stb(frm_stb), .idx(frm_idx), .oof(oof),
    .sel(cw_sel), .sa_in(ts0_byte[SA_MSB:0]), .cw(nat_cw)
  );

  ovx_link_detect #(.WIN(LINK_WIN), .MIN_Z(LINK_MINZ)) u_link (
    .clk(clk), .rst(rst), .shift(frm_stb && nfas && !oof),
    .bit_in(ts0_byte[SA7_POS]), .link(link_id)
  );

  assert_si_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(oof)) |-> $stable(si_bits));
  assert_sa_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(oof)) |-> $stable(sa_bits));
  assert_a_on_nfas_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(a_bit)) |-> $past(frm_stb && nfas));
  assert_xy_staged_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable({x_bits, y_bit})) |-> $past(frm_stb && xy_pend));
  assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (si_bits == '0 && sa_bits == '0 && !a_bit && x_bits == '0 && !y_bit && !link_id));
endmodule

// File: tb/sim_ovx_extract.sv
`timescale 1ns/1ps
module sim_ovx_extract;
  logic clk = 0, rst = 1;
  logic frm_stb = 0, oof = 0, smf_start = 0;
  logic [2:0] frm_idx = 0, cw_sel = 0;
  logic [7:0] ts0_byte = 0, ts16_byte = 0;
  logic [1:0] si_bits; logic [4:0] sa_bits; logic a_bit;
  logic [2:0] x_bits; logic y_bit; logic [3:0] nat_cw; logic link_id;

  int n_cmp = 0, n_bad = 0;
  // reference state
  logic [1:0] m_si; logic [4:0] m_sa; logic m_a, m_y, m_py, m_pend, m_link, m_hv;
  logic [2:0] m_x, m_px; logic [3:0] m_cw, m_hist, m_part;
  int m_cnt; bit m_q[$];
  int idx_ctr = 0;

  always #2.5 clk = ~clk;

  ovx_extract u0 (.clk(clk), .rst(rst), .frm_stb(frm_stb), .frm_idx(frm_idx), .oof(oof),
    .ts0_byte(ts0_byte), .smf_start(smf_start), .ts16_byte(ts16_byte), .cw_sel(cw_sel),
    .si_bits(si_bits), .sa_bits(sa_bits), .a_bit(a_bit), .x_bits(x_bits), .y_bit(y_bit),
    .nat_cw(nat_cw), .link_id(link_id));

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_si = 0; m_sa = 0; m_a = 0; m_x = 0; m_y = 0; m_px = 0; m_py = 0; m_pend = 0;
    m_cw = 0; m_hist = 0; m_part = 0; m_cnt = 0; m_hv = 0; m_link = 0; m_q.delete();
  endtask

  always @(posedge clk) begin
    #1;
    chk("R2 nat_cw", nat_cw, m_cw);
    chk("R3 si_bits", si_bits, m_si);
    chk("R4 sa_bits", sa_bits, m_sa);
    chk("R5 a_bit", a_bit, m_a);
    chk("R6 x_bits", x_bits, m_x);
    chk("R6 y_bit", y_bit, m_y);
    chk("R7 link_id", link_id, m_link);
  end

  // drive one frame and advance the reference model
  task automatic frame(input logic [7:0] b0, input logic [7:0] b16, input bit smf, input bit of);
    int p, z; bit b;
    @(negedge clk);
    frm_stb = 1; frm_idx = 3'(idx_ctr); ts0_byte = b0; ts16_byte = b16;
    smf_start = smf; oof = of;
    if (!of) begin
      if (idx_ctr % 2) begin m_si[0] = b0[7]; m_sa = b0[4:0]; end
      else m_si[1] = b0[7];
    end
    if (idx_ctr % 2) m_a = b0[5];
    if (m_pend) begin m_x = m_px; m_y = m_py; end
    m_pend = smf;
    if (smf) begin m_px = {b16[3], b16[1], b16[0]}; m_py = b16[2]; end
    // R1 / R10: gather one codeword bit per odd frame
    if (of || cw_sel > 4) m_cnt = 0;
    else if (idx_ctr % 2) begin
      p = idx_ctr / 2; b = b0[4 - cw_sel];
      if (p == 0) begin m_part[3] = b; m_cnt = 1; end
      else if (p == m_cnt) begin
        m_part[3 - p] = b;
        if (p == 3) begin
          if (m_hv && m_hist == m_part) m_cw = m_part;
          m_hist = m_part; m_hv = 1; m_cnt = 0;
        end else m_cnt++;
      end else m_cnt = 0;
    end
    if ((idx_ctr % 2) && !of) begin
      m_q.push_back(b0[1]);
      if (m_q.size() > 3) void'(m_q.pop_front());
      z = 0; foreach (m_q[i]) if (!m_q[i]) z++;
      m_link = (z >= 2);
    end
    idx_ctr = (idx_ctr + 1) % 8;
    @(negedge clk);
    frm_stb = 0; smf_start = 0; oof = 0;
  endtask

  task automatic set_sel(input logic [2:0] s);
    @(negedge clk);
    if (s != cw_sel) begin m_cnt = 0; m_hv = 0; end // R9
    cw_sel = s;
  endtask

  // fixed pattern: Sa4 over frames 1,3,5,7 = 1,0,1,1 ; Sa7 all zero
  function automatic logic [7:0] pat(input int i);
    logic [7:0] v;
    v = 8'h40;
    if (i % 2) v = (i == 3) ? 8'h80 : 8'h90;
    return v;
  endfunction

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    // R8: reset state
    chk("R8 reset cw", nat_cw, 0);
    chk("R8 reset link", link_id, 0);
    @(negedge clk); rst = 0;
    // R1: repeated codeword with select 0
    for (int k = 0; k < 24; k++) frame(pat(idx_ctr), 8'h0D, (k % 16) == 0, 0);
    #1;
    chk("R1 codeword value", nat_cw, 4'hB);
    chk("R7 sa7 zeros", link_id, 1);
    // R9: select change then one codeword must not update
    set_sel(3'd3);
    for (int k = 0; k < 8; k++) frame(8'h10 | 8'(k[0]) << 1, 8'h00, 0, 0);
    #1;
    chk("R9 first after change", nat_cw, 4'hB);
    // R10: out-of-range select
    set_sel(3'd6);
    for (int k = 0; k < 16; k++) frame(8'($urandom), 8'($urandom), k == 3, 0);
    #1;
    chk("R10 sel out of range", nat_cw, 4'hB);
    // random traffic with select sweeps and oof bursts
    for (int s = 0; s < 8; s++) begin
      set_sel(3'(s));
      for (int k = 0; k < 80; k++) begin
        logic [7:0] b;
        b = ((k / 8) % 3 == 0) ? 8'($urandom) : ((idx_ctr % 2) ? 8'hB5 : 8'h1B);
        frame(b, 8'($urandom), ($urandom % 6) == 0, ($urandom % 9) == 0);
      end
    end
    // R3/R4: long out-of-frame burst holds Si and Sa
    for (int k = 0; k < 12; k++) frame(8'($urandom), 8'($urandom), 0, 1);
    // R7: Sa7 ones clear link
    for (int k = 0; k < 8; k++) frame(8'h02, 8'h00, 0, 0);
    #1;
    chk("R7 sa7 ones", link_id, 0);
    repeat (4) @(negedge clk);
    // R8: reset in mid-stream
    rst = 1; model_reset();
    repeat (2) @(negedge clk);
    rst = 0; idx_ctr = 0;
    for (int k = 0; k < 8; k++) frame(pat(idx_ctr), 8'h00, 0, 0);
    #1;
    chk("R8 first codeword after reset", nat_cw, 0);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule